// File: doc/BRIEF.md
# Decimal Floating-Point Interchange Encoder

This block takes a decimal floating-point value in working form and packs it into a 32-bit or 64-bit interchange word. The inputs are a sign, a signed unbiased exponent, a coefficient of sixteen BCD digits, a width select, and requests for infinity and NaN. A single start pulse launches an encode. The block first forms the 5-bit combination field from the leading coefficient digit and the two most significant bits of the biased exponent. It then compresses the remaining digits three at a time into 10-bit declets in densely packed decimal form, issuing one declet per clock from the most significant triple downward. When the coefficient is complete, the block presents the finished word with a one-cycle done pulse.

The controller has three states. `ST_IDLE` waits for start. `ST_PACK` emits one declet per cycle. `ST_FINISH` raises done and presents the word. The transitions are as follows. Start with an ordinary operand goes from `ST_IDLE` to `ST_PACK`. Start with a special value or an out-of-range exponent goes from `ST_IDLE` straight to `ST_FINISH`. The last declet goes from `ST_PACK` to `ST_FINISH`. `ST_FINISH` always returns to `ST_IDLE` on the next cycle. The word and error flag then hold until the next accepted start.

Rounding, the choice of an ideal exponent and the 128-bit width lie outside this block. The caller must supply valid BCD digits (0 to 9).

Top module: `dfp_encoder`

## Requirements
- R1: With `fmt_wide`=0 the word is {sign, 5-bit combination, 6-bit exponent continuation, 20-bit coefficient continuation} in bits 31:0, and bits 63:32 are zero. With `fmt_wide`=1 it is {sign, combination, 8-bit exponent continuation, 50-bit coefficient continuation} in bits 63:0.
- R2: The biased exponent is the input exponent plus 101 (narrow) or 398 (wide). Its low 6 or 8 bits form the exponent continuation, and its top two bits enter the combination field.
- R3: The leading digit is digit 6 (`coef_bcd[27:24]`) for narrow and digit 15 (`coef_bcd[63:60]`) for wide. When it is 0 to 7, the combination field is {exponent top two bits, digit[2:0]}.
- R4: When the leading digit is 8 or 9, the combination field is {2'b11, exponent top two bits, digit[0]}.
- R5: A NaN request gives combination 11111 and an infinity request gives 11110, with NaN taking precedence. The sign is kept, all other fields are zero, no declets are issued and no range error is raised.
- R6: A triple with all digits in 0 to 7 encodes as {high[2:0], mid[2:0], 0, low[2:0]}.
- R7: A triple with exactly one digit of 8 or 9 has declet bit 3 set and bits 2:1 equal to 00 (low large), 01 (middle large) or 10 (high large). The displaced low-digit bits fill the freed positions, and bit 0 is always low[0].
- R8: A triple with two or three large digits has bits 3:1 equal to 111. Bits 6:5 are then 10 for middle and low large, 01 for high and low, 00 for high and middle, and 11 for all three.
- R9: An ordinary encode issues exactly 2 (narrow) or 5 (wide) declets on consecutive cycles, starting the cycle after start, from the most significant triple to the least significant.
- R10: A leading digit of zero is encoded unchanged (no normalization).
- R11: If the biased exponent falls outside 0 to 191 (narrow) or 0 to 767 (wide), `err` is 1 and the word is all zeros.
- R12: A start pulse while `busy` is high is ignored, and the running encode completes with its original operands.
- R13: `done` is high for exactly one cycle, immediately after the last declet (or one cycle after start for specials and errors). `busy` is high from the cycle after start through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an encode (sampled while idle) |
| fmt_wide | input | 1 | 0 = 32-bit word, 1 = 64-bit word |
| sign_in | input | 1 | Sign of the value |
| exp_in | input | 11 | Signed unbiased exponent |
| coef_bcd | input | 64 | Sixteen BCD digits, digit i at bits 4i+3:4i |
| want_inf | input | 1 | Encode infinity |
| want_nan | input | 1 | Encode NaN |
| busy | output | 1 | Encode in progress |
| declet_valid | output | 1 | A declet is presented this cycle |
| declet | output | 10 | Current declet |
| done | output | 1 | Word complete (one cycle) |
| err | output | 1 | Exponent out of range |
| word | output | 64 | Encoded word |

## Verification
The bench sweeps every pattern of large digits within a triple, because swapping a single pair of bits in any of the eight declet layouts produces a valid-looking but wrong word. It probes the exponent exactly at both representable limits and one step beyond each. An off-by-one bound would either reject the smallest or largest exponent or let the top bits reach 11 and collide with the special codes. Leading digits of 0, 7, 8 and 9 are exercised, since a wrong split between the two combination layouts corrupts both the exponent and the digit. Start pulses injected mid-encode, infinity and NaN requested together, and random mixes in both widths guard against lost operands, a wrong precedence and a wrong declet count or order.

// File: rtl/dfpe_pkg.sv
package dfpe_pkg;
    localparam int DIG_W     = 4;
    localparam int N_DIGITS  = 16;
    localparam int COEF_W    = DIG_W * N_DIGITS;
    localparam int DEC_W     = 10;
    localparam int TRIPLE_W  = 3 * DIG_W;
    localparam int EXP_W     = 11;
    localparam int CF_W      = 5;
    localparam int WORD_W    = 64;
    localparam int NARROW_W  = 32;
    localparam int XC_N      = 6;
    localparam int XC_W      = 8;
    localparam int NDEC_N    = 2;
    localparam int NDEC_W    = 5;
    localparam int CC_N      = NDEC_N * DEC_W;
    localparam int CC_W      = NDEC_W * DEC_W;
    localparam int BIAS_N    = 101;
    localparam int BIAS_W    = 398;
    localparam int BEXP_W    = EXP_W + 1;
    localparam int LIMIT_N   = 3 * (1 << XC_N) - 1;
    localparam int LIMIT_W   = 3 * (1 << XC_W) - 1;
    localparam int REM_W     = TRIPLE_W * NDEC_W;
    localparam int IDX_W     = $clog2(NDEC_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PACK,
        ST_FINISH
    } dfpe_state_t;
endpackage

// File: rtl/dfpe_declet.sv
module dfpe_declet
    import dfpe_pkg::*;
(
    input  logic [TRIPLE_W-1:0] triple,
    output logic [DEC_W-1:0]    declet
);
    logic [DIG_W-1:0] hi, mi, lo;

    always_comb begin
        hi = triple[3*DIG_W-1:2*DIG_W];
        mi = triple[2*DIG_W-1:DIG_W];
        lo = triple[DIG_W-1:0];
        unique case ({hi[3], mi[3], lo[3]})
            3'b000: declet = {hi[2:0], mi[2:0], 1'b0, lo[2:0]};
            3'b001: declet = {hi[2:0], mi[2:0], 3'b100, lo[0]};
            3'b010: declet = {hi[2:0], lo[2:1], mi[0], 3'b101, lo[0]};
            3'b100: declet = {lo[2:1], hi[0], mi[2:0], 3'b110, lo[0]};
            3'b011: declet = {hi[2:0], 2'b10, mi[0], 3'b111, lo[0]};
            3'b101: declet = {mi[2:1], hi[0], 2'b01, mi[0], 3'b111, lo[0]};
            3'b110: declet = {lo[2:1], hi[0], 2'b00, mi[0], 3'b111, lo[0]};
            3'b111: declet = {2'b00, hi[0], 2'b11, mi[0], 3'b111, lo[0]};
            default: declet = '0;
        endcase
    end
endmodule

// File: rtl/dfpe_comb_field.sv
module dfpe_comb_field
    import dfpe_pkg::*;
(
    input  logic [DIG_W-1:0] lead,
    input  logic [1:0]       exp_top,
    input  logic             is_inf,
    input  logic             is_nan,
    output logic [CF_W-1:0]  cf
);
    always_comb begin
        if (is_nan)
            cf = 5'b11111;
        else if (is_inf)
            cf = 5'b11110;
        else if (lead[3])
            cf = {2'b11, exp_top, lead[0]};
        else
            cf = {exp_top, lead[2:0]};
    end
endmodule

// File: rtl/dfpe_exp_bias.sv
module dfpe_exp_bias
    import dfpe_pkg::*;
(
    input  logic                    wide,
    input  logic signed [EXP_W-1:0] exp_u,
    output logic [XC_W+1:0]         biased,
    output logic                    in_range
);
    logic signed [BEXP_W-1:0] sum;
    logic signed [BEXP_W-1:0] bias;
    logic signed [BEXP_W-1:0] limit;

    always_comb begin
        bias     = wide ? BEXP_W'(BIAS_W) : BEXP_W'(BIAS_N);
        limit    = wide ? BEXP_W'(LIMIT_W) : BEXP_W'(LIMIT_N);
        sum      = {exp_u[EXP_W-1], exp_u} + bias;
        in_range = !sum[BEXP_W-1] && (sum <= limit);
        biased   = sum[XC_W+1:0];
    end
endmodule

// File: rtl/dfp_encoder.sv
module dfp_encoder
    import dfpe_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    fmt_wide,
    input  logic                    sign_in,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic [COEF_W-1:0]       coef_bcd,
    input  logic                    want_inf,
    input  logic                    want_nan,
    output logic                    busy,
    output logic                    declet_valid,
    output logic [DEC_W-1:0]        declet,
    output logic                    done,
    output logic                    err,
    output logic [WORD_W-1:0]       word
);
    dfpe_state_t state, state_nx;

    logic [XC_W+1:0]   biased;
    logic              in_range;
    logic [DIG_W-1:0]  lead;
    logic [CF_W-1:0]   cf_new;
    logic              special;
    logic              accept;
    logic              last_dec;

    logic [IDX_W-1:0]  idx_q;
    logic [REM_W-1:0]  rem_q;
    logic [CC_W-1:0]   cc_q;
    logic [CC_W-1:0]   cc_nx;
    logic              sign_q;
    logic              wide_q;
    logic [CF_W-1:0]   cf_q;
    logic [XC_W-1:0]   xc_q;
    logic [DEC_W-1:0]  dec_cur;

    dfpe_exp_bias u_bias (
        .wide     (fmt_wide),
        .exp_u    (exp_in),
        .biased   (biased),
        .in_range (in_range)
    );

    assign lead = fmt_wide ? coef_bcd[COEF_W-1 -: DIG_W]
                           : coef_bcd[7*DIG_W-1 -: DIG_W];

    dfpe_comb_field u_cf (
        .lead    (lead),
        .exp_top (fmt_wide ? biased[XC_W+1:XC_W] : biased[XC_N+1:XC_N]),
        .is_inf  (want_inf),
        .is_nan  (want_nan),
        .cf      (cf_new)
    );

    dfpe_declet u_dpd (
        .triple (rem_q[REM_W-1 -: TRIPLE_W]),
        .declet (dec_cur)
    );

    assign special  = want_inf || want_nan;
    assign accept   = (state == ST_IDLE) && start;
    assign last_dec = (idx_q == IDX_W'(wide_q ? NDEC_W - 1 : NDEC_N - 1));
    assign cc_nx    = {cc_q[CC_W-DEC_W-1:0], dec_cur};

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = (special || !in_range) ? ST_FINISH : ST_PACK;
            ST_PACK:   if (last_dec) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            rem_q  <= '0;
            cc_q   <= '0;
            sign_q <= 1'b0;
            wide_q <= 1'b0;
            cf_q   <= '0;
            xc_q   <= '0;
            err    <= 1'b0;
            word   <= '0;
        end else if (accept) begin
            idx_q  <= '0;
            cc_q   <= '0;
            sign_q <= sign_in;
            wide_q <= fmt_wide;
            cf_q   <= cf_new;
            xc_q   <= fmt_wide ? biased[XC_W-1:0] : {2'b00, biased[XC_N-1:0]};
            rem_q  <= fmt_wide ? coef_bcd[REM_W-1:0]
                               : {coef_bcd[NDEC_N*TRIPLE_W-1:0],
                                  {(REM_W-NDEC_N*TRIPLE_W){1'b0}}};
            err    <= !special && !in_range;
            if (special)
                word <= fmt_wide ? {sign_in, cf_new, {(WORD_W-CF_W-1){1'b0}}}
                                 : {{NARROW_W{1'b0}}, sign_in, cf_new,
                                    {(NARROW_W-CF_W-1){1'b0}}};
            else
                word <= '0;
        end else if (state == ST_PACK) begin
            idx_q <= idx_q + 1'b1;
            rem_q <= {rem_q[REM_W-TRIPLE_W-1:0], {TRIPLE_W{1'b0}}};
            cc_q  <= cc_nx;
            if (last_dec)
                word <= wide_q ? {sign_q, cf_q, xc_q, cc_nx}
                               : {{NARROW_W{1'b0}}, sign_q, cf_q,
                                  xc_q[XC_N-1:0], cc_nx[CC_N-1:0]};
        end
    end

    // state-decoded outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        declet_valid = (state == ST_PACK);
        done         = (state == ST_FINISH);
        declet       = (state == ST_PACK) ? dec_cur : '0;
    end
endmodule

// File: rtl/dfpe_checker.sv
module dfpe_checker
    import dfpe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              declet_valid,
    input logic              done,
    input logic              err,
    input logic [WORD_W-1:0] word
);
    logic [3:0] n_dec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                n_dec <= '0;
        else if (!busy && start)   n_dec <= '0;
        else if (declet_valid)     n_dec <= n_dec + 1'b1;
    end

    p_done_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    p_hold_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_declet_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        declet_valid |-> (busy && !done));
    p_declet_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (n_dec == 4'd0 || n_dec == 4'd2 || n_dec == 4'd5));
    p_narrow_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && n_dec == 4'd2) |-> (word[WORD_W-1:NARROW_W] == '0));
    p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (word == '0 && n_dec == 4'd0));
endmodule

bind dfp_encoder dfpe_checker u_dfpe_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .declet_valid (declet_valid),
    .done         (done),
    .err          (err),
    .word         (word)
);

// File: tb/tb_dfp_encoder.sv
module tb_dfp_encoder;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               fmt_wide = 1'b0;
    logic               sign_in = 1'b0;
    logic signed [10:0] exp_in = '0;
    logic [63:0]        coef_bcd = '0;
    logic               want_inf = 1'b0;
    logic               want_nan = 1'b0;
    logic               busy, declet_valid, done, err;
    logic [9:0]         declet;
    logic [63:0]        word;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dfp_encoder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_wide(fmt_wide),
        .sign_in(sign_in), .exp_in(exp_in), .coef_bcd(coef_bcd),
        .want_inf(want_inf), .want_nan(want_nan), .busy(busy),
        .declet_valid(declet_valid), .declet(declet), .done(done),
        .err(err), .word(word)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=fewer", cycles);
            summary();
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] ref_declet(input logic [3:0] h, input logic [3:0] m, input logic [3:0] l);
        logic [9:0] d;
        int nbig;
        nbig = int'(h[3]) + int'(m[3]) + int'(l[3]);
        d = '0;
        d[0] = l[0];
        if (nbig == 0) begin
            d[9:7] = h[2:0]; d[6:4] = m[2:0]; d[3] = 1'b0; d[2:0] = l[2:0];
        end else if (nbig == 1) begin
            d[3] = 1'b1;
            if (l[3]) begin
                d[9:7] = h[2:0]; d[6:4] = m[2:0]; d[2:1] = 2'b00;
            end else if (m[3]) begin
                d[9:7] = h[2:0]; d[6:5] = l[2:1]; d[4] = m[0]; d[2:1] = 2'b01;
            end else begin
                d[9:8] = l[2:1]; d[7] = h[0]; d[6:4] = m[2:0]; d[2:1] = 2'b10;
            end
        end else begin
            d[3:1] = 3'b111; d[4] = m[0];
            if (nbig == 3) begin
                d[9:8] = 2'b00; d[7] = h[0]; d[6:5] = 2'b11;
            end else if (!h[3]) begin
                d[9:7] = h[2:0]; d[6:5] = 2'b10;
            end else if (!m[3]) begin
                d[9:8] = m[2:1]; d[7] = h[0]; d[6:5] = 2'b01;
            end else begin
                d[9:8] = l[2:1]; d[7] = h[0]; d[6:5] = 2'b00;
            end
        end
        return d;
    endfunction

    function automatic logic [9:0] ref_triple(input logic w, input logic [63:0] c, input int k);
        int top;
        top = (w ? 14 : 5) - 3 * k;
        return ref_declet(c[4*top +: 4], c[4*(top-1) +: 4], c[4*(top-2) +: 4]);
    endfunction

    function automatic logic [64:0] ref_word(input logic w, input logic s, input int e,
                                             input logic [63:0] c, input logic fi, input logic fn);
        int b, lim, xcw, nd;
        logic [3:0] ld;
        logic [1:0] top2;
        logic [4:0] cf;
        logic [49:0] cc;
        logic [63:0] r;
        xcw = w ? 8 : 6;
        nd  = w ? 5 : 2;
        b   = e + (w ? 398 : 101);
        lim = 3 * (1 << xcw) - 1;
        if (fn || fi) begin
            cf = fn ? 5'b11111 : 5'b11110;
            r = w ? {s, cf, 58'd0} : {32'd0, s, cf, 26'd0};
            return {1'b0, r};
        end
        if (b < 0 || b > lim) return {1'b1, 64'd0};
        ld   = w ? c[63:60] : c[27:24];
        top2 = 2'(b >> xcw);
        cf   = (ld > 4'd7) ? {2'b11, top2, ld[0]} : {top2, ld[2:0]};
        cc = '0;
        for (int k = 0; k < nd; k++) cc = {cc[39:0], ref_triple(w, c, k)};
        if (w) r = {s, cf, 8'(b), cc};
        else   r = {32'd0, s, cf, 6'(b), cc[19:0]};
        return {1'b0, r};
    endfunction

    task automatic run_case(input logic w, input logic s, input int e, input logic [63:0] c,
                            input logic fi, input logic fn, input logic poke, input string req);
        logic [64:0] ew;
        int nd;
        ew = ref_word(w, s, e, c, fi, fn);
        nd = (fi || fn || ew[64]) ? 0 : (w ? 5 : 2);
        @(negedge clk);
        fmt_wide = w; sign_in = s; exp_in = 11'(e); coef_bcd = c;
        want_inf = fi; want_nan = fn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R13 busy after start"}, 64'(busy), 64'd1);
        for (int k = 0; k < nd; k++) begin
            check({req, " R9 declet_valid"}, 64'(declet_valid), 64'd1);
            check({req, " R6/R7/R8 declet"}, 64'(declet), 64'(ref_triple(w, c, k)));
            if (poke && k == 0) begin
                start = 1'b1; fmt_wide = ~w; coef_bcd = ~c;
                exp_in = 11'sd900; want_nan = 1'b1; sign_in = ~s;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check({req, " R13 done"}, 64'(done), 64'd1);
        check({req, " R9 no declet at done"}, 64'(declet_valid), 64'd0);
        check({req, " R11 err"}, 64'(err), 64'(ew[64]));
        check({req, " word"}, word, ew[63:0]);
        @(negedge clk);
        check({req, " R13 done single"}, 64'(done), 64'd0);
        check({req, " R13 idle"}, 64'(busy), 64'd0);
        check({req, " word held"}, word, ew[63:0]);
    endtask

    function automatic logic [63:0] rand_coef(input int bigpct);
        logic [63:0] c;
        for (int i = 0; i < 16; i++)
            c[4*i +: 4] = ($urandom_range(0, 99) < bigpct) ? 4'(8 + $urandom_range(0, 1))
                                                           : 4'($urandom_range(0, 7));
        return c;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R13 reset busy", 64'(busy), 64'd0);
        check("R13 reset done", 64'(done), 64'd0);
        check("R11 reset err", 64'(err), 64'd0);
        check("R1 reset word", word, 64'd0);
        rst_n = 1'b1;

        // every large-digit pattern in one triple (R6, R7, R8)
        for (int p = 0; p < 8; p++) begin
            logic [63:0] c;
            c = 64'h0000_0000_0123_4567;
            c[23:20] = p[2] ? 4'h9 : 4'h3;
            c[19:16] = p[1] ? 4'h8 : 4'h6;
            c[15:12] = p[0] ? 4'h9 : 4'h5;
            run_case(1'b0, 1'b0, 0, c, 1'b0, 1'b0, 1'b0, "R6 R7 R8 pattern");
        end
        run_case(1'b1, 1'b1, 0, 64'h9999_9999_9999_9999, 1'b0, 1'b0, 1'b0, "R8 all nines");
        // leading digit 0, 7, 8, 9 (R3, R4, R10)
        run_case(1'b0, 1'b0, 5,   64'h0000_0000_0012_3456, 1'b0, 1'b0, 1'b0, "R10 lead zero");
        run_case(1'b1, 1'b0, -7,  64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0, "R10 wide lead zero");
        run_case(1'b0, 1'b1, 40,  64'h0000_0000_0765_4321, 1'b0, 1'b0, 1'b0, "R3 lead seven");
        run_case(1'b1, 1'b0, 300, 64'h8123_4567_8901_2345, 1'b0, 1'b0, 1'b0, "R4 lead eight");
        run_case(1'b0, 1'b0, 90,  64'h0000_0000_0912_3456, 1'b0, 1'b0, 1'b0, "R4 R2 lead nine max exp");
        // exponent limits (R2, R11)
        run_case(1'b0, 1'b0, -101, 64'h0000_0000_0111_1111, 1'b0, 1'b0, 1'b0, "R2 narrow min");
        run_case(1'b0, 1'b0, -102, 64'h0000_0000_0111_1111, 1'b0, 1'b0, 1'b0, "R11 narrow below");
        run_case(1'b0, 1'b1, 91,   64'h0000_0000_0111_1111, 1'b0, 1'b0, 1'b0, "R11 narrow above");
        run_case(1'b1, 1'b0, -398, 64'h1234_5678_9012_3456, 1'b0, 1'b0, 1'b0, "R2 wide min");
        run_case(1'b1, 1'b0, 369,  64'h1234_5678_9012_3456, 1'b0, 1'b0, 1'b0, "R2 wide max");
        run_case(1'b1, 1'b0, -399, 64'h1234_5678_9012_3456, 1'b0, 1'b0, 1'b0, "R11 wide below");
        run_case(1'b1, 1'b1, 370,  64'h1234_5678_9012_3456, 1'b0, 1'b0, 1'b0, "R11 wide above");
        // specials (R5)
        run_case(1'b0, 1'b1, 500, 64'h0000_0000_0999_9999, 1'b1, 1'b0, 1'b0, "R5 narrow inf");
        run_case(1'b1, 1'b0, 0,   64'h9999_9999_9999_9999, 1'b0, 1'b1, 1'b0, "R5 wide nan");
        run_case(1'b1, 1'b1, 0,   64'h1111_1111_1111_1111, 1'b1, 1'b1, 1'b0, "R5 nan over inf");
        // start while busy (R12)
        run_case(1'b0, 1'b0, 3,  64'h0000_0000_0987_6543, 1'b0, 1'b0, 1'b1, "R12 poke narrow");
        run_case(1'b1, 1'b1, -3, 64'h5432_1098_7654_3210, 1'b0, 1'b0, 1'b1, "R12 poke wide");

        // random mix (R1 R9 and all above)
        for (int n = 0; n < 400; n++) begin
            logic w;
            int e, span, bias;
            w    = 1'($urandom_range(0, 1));
            span = w ? 768 : 192;
            bias = w ? 398 : 101;
            if ($urandom_range(0, 7) == 0)
                e = $urandom_range(0, 1) ? (span - bias + $urandom_range(0, 20))
                                         : (-bias - 1 - $urandom_range(0, 20));
            else
                e = $urandom_range(0, span - 1) - bias;
            run_case(w, 1'($urandom_range(0, 1)), e, rand_coef($urandom_range(0, 60)),
                     $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0,
                     $urandom_range(0, 5) == 0, "R1 R9 random");
        end
        summary();
    end
endmodule